// File: doc/BRIEF.md
# Parallel Output Clock-Gating Formatter

This block is the last stage before an 8-bit parallel pixel or compressed-data port. It takes a beat stream from an upstream source (frame flag, line flag, data-valid flag and a byte) and drives the port's frame-valid, line-valid and data wires together with a gated pixel clock. Every byte is launched on a rising edge of the core clock. The pixel-clock pulse that marks a byte comes one core-clock cycle after it.

There are three operating modes: bypass, continuous and fixed-frame. Per-mode enable bits decide whether the pixel clock keeps running through frame blanking, through line blanking (bypass and fixed-frame) or through cycles that carry no valid byte (continuous). In continuous mode the block can frame each image with start-of-image and end-of-image markers. In bypass mode it can replace the valid wires with four-byte embedded timing codes. In both cases the upstream source is held off through a ready signal while the extra bytes go out. The configuration is captured only while no frame is in progress.

Top module: `par_out_fmt`

## Requirements
- R1: While reset is high and in the cycle after it falls, out_fv, out_lv and out_data are 0, out_pclk stays low and up_ready is 1 while the upstream beat is blank.
- R2: In bypass (cfg_mode 00) or fixed-frame (10 or 11) mode without embedded codes, each accepted beat appears on the port one cycle later with out_fv = up_fv, out_lv = up_fv & up_lv, and out_data = up_data when out_lv is 1 and 0 otherwise.
- R3: In every mode, out_pclk pulses in frame blanking (out_fv low) only when cfg_clk_frame_blank is 1.
- R4: In bypass and fixed-frame modes, out_pclk pulses on in-frame cycles without line activity only when cfg_clk_line_blank is 1; it always pulses for line bytes.
- R5: In continuous mode (cfg_mode 01), out_lv marks valid bytes (up_fv & up_dv), and out_pclk pulses on in-frame cycles without a valid byte only when cfg_clk_invalid is 1.
- R6: In continuous mode with cfg_jpeg_marks set, the byte pair FF D8 precedes the first byte of a frame and FF D9 follows its last byte. Both pairs go out with out_fv and out_lv high, and up_ready is low for exactly two cycles per pair.
- R7: In bypass mode with cfg_embed_sync set, out_fv and out_lv stay low. FF 00 00 XY precedes each line and FF 00 00 XY follows it, and up_ready is low for four cycles per code. XY is {1, F, V, H, V^H, F^H, F^V, F^V^H}, with V = 0 and with H = 0 before a line and 1 after it.
- R8: The F bit is 0 for the first frame after reset and flips at the end of every frame, whatever the mode.
- R9: Mode and enable inputs take effect only when captured outside a frame; a change during a frame has no effect until that frame ends.
- R10: out_pclk is never high while the core clock is low.
- R11: In continuous mode with cfg_jpeg_marks clear, the port carries exactly the valid upstream bytes with no inserted bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 00 bypass, 01 continuous, 10/11 fixed-frame |
| cfg_clk_frame_blank | input | 1 | Pixel clock runs in frame blanking |
| cfg_clk_line_blank | input | 1 | Pixel clock runs in line blanking (bypass, fixed-frame) |
| cfg_clk_invalid | input | 1 | Pixel clock runs on invalid cycles (continuous) |
| cfg_jpeg_marks | input | 1 | Insert image start/end markers (continuous) |
| cfg_embed_sync | input | 1 | Use embedded timing codes instead of valid wires (bypass) |
| up_fv | input | 1 | Upstream frame flag |
| up_lv | input | 1 | Upstream line flag |
| up_dv | input | 1 | Upstream byte valid (continuous) |
| up_data | input | 8 | Upstream byte |
| up_ready | output | 1 | Current upstream beat is accepted this cycle |
| out_fv | output | 1 | Port frame valid |
| out_lv | output | 1 | Port line / data valid |
| out_data | output | 8 | Port data |
| out_pclk | output | 1 | Gated pixel clock |

## Verification
The checks assume that the upstream source holds its beat steady until up_ready accepts it, and that the configuration inputs change only during blanking or are meant to be ignored. They also assume that frame flag, line flag and byte valid are nested, so that a line never outlives its frame. The driver enforces all of this. It presents one beat at a time, holds it until it sees up_ready high just before a rising edge, ends every line with line blanking inside the frame, and changes the configuration only across several blank beats. The single exception is the deliberate mid-frame change that exercises R9. In embedded-code mode, data bytes avoid 00 and FF so that the monitor can tell codes from payload.

// File: rtl/pof_pkg.sv
package pof_pkg;

    localparam int BYTE_W   = 8;
    localparam int JPEG_LEN = 2;
    localparam int SYNC_LEN = 4;
    localparam int IDX_W    = $clog2(SYNC_LEN);

    localparam logic [BYTE_W-1:0] MK_LEAD = 8'hFF;
    localparam logic [BYTE_W-1:0] MK_SOI  = 8'hD8;
    localparam logic [BYTE_W-1:0] MK_EOI  = 8'hD9;
    localparam logic [BYTE_W-1:0] MK_ZERO = 8'h00;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'b00,
        MODE_CONT   = 2'b01,
        MODE_FIXED  = 2'b10,
        MODE_FIXED2 = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        INS_SOI,
        INS_EOI,
        INS_SAV,
        INS_EAV
    } ins_e;

    typedef struct packed {
        mode_e mode;
        logic  clk_frame_blank;
        logic  clk_line_blank;
        logic  clk_invalid;
        logic  jpeg_marks;
        logic  embed_sync;
    } cfg_t;

    typedef struct packed {
        logic              fv;
        logic              lv;
        logic              dv;
        logic [BYTE_W-1:0] data;
    } beat_t;

    typedef struct packed {
        logic              frame;
        logic              active;
        logic              hide;
        logic [BYTE_W-1:0] data;
    } obeat_t;

    function automatic logic [BYTE_W-1:0] sync_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic is_code(input ins_e k);
        return (k == INS_SAV) || (k == INS_EAV);
    endfunction

    function automatic logic [IDX_W-1:0] last_index(input ins_e k);
        return is_code(k) ? IDX_W'(SYNC_LEN - 1) : IDX_W'(JPEG_LEN - 1);
    endfunction

    function automatic logic [BYTE_W-1:0] ins_byte(input ins_e k, input logic [IDX_W-1:0] idx,
                                                   input logic f);
        logic [BYTE_W-1:0] b;
        if (idx == '0) begin
            b = MK_LEAD;
        end else if (!is_code(k)) begin
            b = (k == INS_SOI) ? MK_SOI : MK_EOI;
        end else if (idx == IDX_W'(SYNC_LEN - 1)) begin
            b = sync_word(f, 1'b0, k == INS_EAV);
        end else begin
            b = MK_ZERO;
        end
        return b;
    endfunction

endpackage

// File: rtl/pof_cfg_hold.sv
module pof_cfg_hold
    import pof_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg_in,
    input  logic open_i,
    output cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (open_i) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/pof_sequencer.sv
module pof_sequencer
    import pof_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cfg_t   cfg,
    input  beat_t  beat,
    output logic   ready,
    output obeat_t ob,
    output logic   in_frame,
    output logic   open_o
);
    logic             prev_fv;
    logic             prev_lv;
    logic             handled;
    logic             active;
    logic             field;
    ins_e             kind_q;
    logic [IDX_W-1:0] idx_q;

    logic             cont_mk;
    logic             sync_on;
    logic             is_cont;
    logic             cur_line;
    logic             trig;
    ins_e             kind_n;
    logic             need;
    logic             start;
    logic             consume;
    ins_e             kind;
    logic [IDX_W-1:0] idx;
    logic             emitting;
    logic             beat_active;

    assign is_cont  = (cfg.mode == MODE_CONT);
    assign cont_mk  = is_cont && cfg.jpeg_marks;
    assign sync_on  = (cfg.mode == MODE_BYPASS) && cfg.embed_sync;
    assign cur_line = beat.fv & beat.lv;

    always_comb begin
        trig   = 1'b0;
        kind_n = INS_SOI;
        if (cont_mk) begin
            if (!prev_fv && beat.fv) begin
                trig   = 1'b1;
                kind_n = INS_SOI;
            end else if (prev_fv && !beat.fv) begin
                trig   = 1'b1;
                kind_n = INS_EOI;
            end
        end else if (sync_on) begin
            if (!prev_lv && cur_line) begin
                trig   = 1'b1;
                kind_n = INS_SAV;
            end else if (prev_lv && !cur_line) begin
                trig   = 1'b1;
                kind_n = INS_EAV;
            end
        end
    end

    assign need     = trig && !handled;
    assign start    = !active && need;
    assign consume  = !active && !need;
    assign emitting = active || start;
    assign kind     = active ? kind_q : kind_n;
    assign idx      = active ? idx_q : '0;
    assign ready    = consume;
    assign in_frame = prev_fv;
    assign open_o   = !prev_fv && !active && !handled;

    assign beat_active = is_cont ? (beat.fv & beat.dv) : cur_line;

    always_comb begin
        ob.hide = sync_on;
        if (emitting) begin
            ob.frame  = 1'b1;
            ob.active = 1'b1;
            ob.data   = ins_byte(kind, idx, field);
        end else begin
            ob.frame  = beat.fv;
            ob.active = beat_active;
            ob.data   = beat_active ? beat.data : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_fv <= 1'b0;
            prev_lv <= 1'b0;
            handled <= 1'b0;
            active  <= 1'b0;
            field   <= 1'b0;
            kind_q  <= INS_SOI;
            idx_q   <= '0;
        end else begin
            if (emitting) begin
                if (idx == last_index(kind)) begin
                    active  <= 1'b0;
                    handled <= 1'b1;
                end else begin
                    active <= 1'b1;
                    kind_q <= kind;
                    idx_q  <= idx + 1'b1;
                end
            end
            if (consume) begin
                handled <= 1'b0;
                prev_fv <= beat.fv;
                prev_lv <= cur_line;
                if (prev_fv && !beat.fv) begin
                    field <= ~field;
                end
            end
        end
    end
endmodule

// File: rtl/pof_clk_gate.sv
module pof_clk_gate
    import pof_pkg::*;
(
    input  logic clk,
    input  cfg_t cfg,
    input  logic frame,
    input  logic active,
    output logic pclk
);
    logic gate_d;
    logic gate_lat;

    always_comb begin
        if (!frame) begin
            gate_d = cfg.clk_frame_blank;
        end else if (cfg.mode == MODE_CONT) begin
            gate_d = active | cfg.clk_invalid;
        end else begin
            gate_d = active | cfg.clk_line_blank;
        end
    end

    always_latch begin
        if (!clk) begin
            gate_lat = gate_d;
        end
    end

    assign pclk = clk & gate_lat;
endmodule

// File: rtl/par_out_fmt.sv
module par_out_fmt
    import pof_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_clk_frame_blank,
    input  logic              cfg_clk_line_blank,
    input  logic              cfg_clk_invalid,
    input  logic              cfg_jpeg_marks,
    input  logic              cfg_embed_sync,
    input  logic              up_fv,
    input  logic              up_lv,
    input  logic              up_dv,
    input  logic [BYTE_W-1:0] up_data,
    output logic              up_ready,
    output logic              out_fv,
    output logic              out_lv,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_pclk
);
    cfg_t   cfg_in;
    cfg_t   cfg_q;
    beat_t  beat;
    obeat_t ob;
    obeat_t oq;
    logic   seq_in_frame;
    logic   seq_open;

    assign cfg_in = '{mode:            mode_e'(cfg_mode),
                      clk_frame_blank: cfg_clk_frame_blank,
                      clk_line_blank:  cfg_clk_line_blank,
                      clk_invalid:     cfg_clk_invalid,
                      jpeg_marks:      cfg_jpeg_marks,
                      embed_sync:      cfg_embed_sync};

    assign beat = '{fv: up_fv, lv: up_lv, dv: up_dv, data: up_data};

    pof_cfg_hold u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_in (cfg_in),
        .open_i (seq_open),
        .cfg_q  (cfg_q)
    );

    pof_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg_q),
        .beat     (beat),
        .ready    (up_ready),
        .ob       (ob),
        .in_frame (seq_in_frame),
        .open_o   (seq_open)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            oq <= '0;
        end else begin
            oq <= ob;
        end
    end

    assign out_fv   = oq.frame & ~oq.hide;
    assign out_lv   = oq.active & ~oq.hide;
    assign out_data = oq.data;

    pof_clk_gate u_gate (
        .clk    (clk),
        .cfg    (cfg_q),
        .frame  (oq.frame),
        .active (oq.active),
        .pclk   (out_pclk)
    );
endmodule

// File: rtl/par_out_fmt_chk.sv
module par_out_fmt_chk
    import pof_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input cfg_t              cfg_q,
    input logic              seq_in_frame,
    input logic              oq_hide,
    input logic              out_fv,
    input logic              out_lv,
    input logic [BYTE_W-1:0] out_data
);
    logic sync_cfg;
    logic mark_cfg;

    assign sync_cfg = (cfg_q.mode == MODE_BYPASS) && cfg_q.embed_sync;
    assign mark_cfg = (cfg_q.mode == MODE_CONT) && cfg_q.jpeg_marks;

    AST_LV_INSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
        out_lv |-> out_fv); // R2

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!oq_hide && !out_lv) |-> (out_data == '0)); // R2

    AST_SOI_LEAD_BYTE: assert property (@(posedge clk) disable iff (rst)
        (mark_cfg && $rose(out_fv)) |-> (out_lv && out_data == MK_LEAD)); // R6

    AST_SOI_CODE_BYTE: assert property (@(posedge clk) disable iff (rst)
        (mark_cfg && $rose(out_fv)) |=> (out_lv && out_data == MK_SOI)); // R6

    AST_SYNC_WIRES_LOW: assert property (@(posedge clk) disable iff (rst)
        (sync_cfg && $past(sync_cfg)) |-> (!out_fv && !out_lv)); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (seq_in_frame && $past(seq_in_frame)) |-> $stable(cfg_q)); // R9
endmodule

bind par_out_fmt par_out_fmt_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_q        (cfg_q),
    .seq_in_frame (seq_in_frame),
    .oq_hide      (oq.hide),
    .out_fv       (out_fv),
    .out_lv       (out_lv),
    .out_data     (out_data)
);

// File: tb/tb_par_out_fmt.sv
module tb_par_out_fmt;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'b00;
    logic       cfg_clk_frame_blank = 1'b0;
    logic       cfg_clk_line_blank  = 1'b0;
    logic       cfg_clk_invalid     = 1'b0;
    logic       cfg_jpeg_marks      = 1'b0;
    logic       cfg_embed_sync      = 1'b0;
    logic       up_fv = 1'b0, up_lv = 1'b0, up_dv = 1'b0;
    logic [7:0] up_data = 8'h00;
    logic       up_ready, out_fv, out_lv, out_pclk;
    logic [7:0] out_data;

    int checks = 0, failures = 0;
    int idle_in = 0, idle_out = 0, stalls = 0, wire_err = 0, low_err = 0;
    int data_ctr = 0, frames_sent = 0, force_cnt = 0;
    bit mon_sync = 1'b0, done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    par_out_fmt dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input string req);
        exp_q.push_back(b);
        tag_q.push_back(req);
    endtask

    function automatic logic [7:0] xy(input logic f, input logic h);
        return {1'b1, f, 1'b0, h, h, f ^ h, f, f ^ h};
    endfunction

    task automatic beat(input logic fv, input logic lv, input logic dv, input logic [7:0] d);
        bit taken = 1'b0;
        up_fv = fv; up_lv = lv; up_dv = dv; up_data = d;
        while (!taken) begin
            #4;
            if (up_ready) taken = 1'b1;
            else stalls++;
            @(negedge clk);
        end
    endtask

    // lines x len bytes, gap blank cycles after each line
    task automatic frame(input int lines, input int len, input int gap, input bit cont,
                         input bit marks, input bit sync, input bit flip, input string req);
        logic f;
        f = frames_sent[0];
        repeat (4) beat(0, 0, 0, 8'h00);
        if (cont && marks) begin push(8'hFF, "R6"); push(8'hD8, "R6"); end
        for (int l = 0; l < lines; l++) begin
            if (sync) begin push(8'hFF, "R7"); push(8'h00, "R7"); push(8'h00, "R7"); push(xy(f, 1'b0), "R8"); end
            for (int k = 0; k < len; k++) begin
                logic [7:0] d;
                d = 8'(1 + (data_ctr % 250));
                data_ctr++;
                push(d, req);
                beat(1, 1, 1, d);
            end
            if (sync) begin push(8'hFF, "R7"); push(8'h00, "R7"); push(8'h00, "R7"); push(xy(f, 1'b1), "R8"); end
            for (int g = 0; g < gap; g++) begin
                beat(1, 0, 0, 8'h00);
                if (flip && l == 0 && g == 0) cfg_clk_line_blank = 1'b1;
            end
        end
        if (cont && marks) begin push(8'hFF, "R6"); push(8'hD9, "R6"); end
        frames_sent++;
        repeat (6) beat(0, 0, 0, 8'h00);
    endtask

    task automatic take(input logic [7:0] d);
        if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected byte", d, 0);
        end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(d == e, t, "byte", d, e);
        end
    endtask

    // monitor: byte launched at one edge is marked by the pclk pulse of the next edge
    initial begin
        logic sfv, slv;
        logic [7:0] sd;
        @(negedge rst);
        forever begin
            @(negedge clk);
            sfv = out_fv; slv = out_lv; sd = out_data;
            #1;
            if (out_pclk) low_err++;
            @(posedge clk);
            #1;
            if (out_pclk) begin
                if (!mon_sync) begin
                    if (slv) take(sd);
                    else if (sfv) idle_in++;
                    else idle_out++;
                end else begin
                    if (sfv || slv) wire_err++;
                    if (force_cnt > 0) begin take(sd); force_cnt--; end
                    else if (sd == 8'hFF) begin take(sd); force_cnt = 3; end
                    else if (sd != 8'h00) take(sd);
                end
            end
        end
    end

    task automatic clear_counts();
        idle_in = 0; idle_out = 0; stalls = 0; wire_err = 0;
    endtask

    task automatic setcfg(input logic [1:0] m, input bit fb, input bit lb, input bit iv,
                          input bit mk, input bit sy);
        cfg_mode = m; cfg_clk_frame_blank = fb; cfg_clk_line_blank = lb;
        cfg_clk_invalid = iv; cfg_jpeg_marks = mk; cfg_embed_sync = sy;
        mon_sync = (m == 2'b00) && sy;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            chk(1'b0, "R1", "watchdog expired", 0, 1);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_fv == 1'b0, "R1", "out_fv in reset", out_fv, 0);
        chk(out_lv == 1'b0, "R1", "out_lv in reset", out_lv, 0);
        chk(out_data == 8'h00, "R1", "out_data in reset", out_data, 0);
        chk(up_ready == 1'b1, "R1", "up_ready in reset", up_ready, 1);
        @(posedge clk); #1;
        chk(out_pclk == 1'b0, "R1", "pclk in reset", out_pclk, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_fv == 1'b0 && out_data == 8'h00, "R1", "outputs after reset", out_data, 0);

        // S1 bypass, clock off in both blankings
        setcfg(2'b00, 0, 0, 0, 0, 0); clear_counts();
        frame(2, 4, 3, 0, 0, 0, 0, "R2");
        chk(idle_in == 0, "R4", "line-blank pulses, gated", idle_in, 0);
        chk(idle_out == 0, "R3", "frame-blank pulses, gated", idle_out, 0);

        // S2 bypass, line-blank clock on
        setcfg(2'b00, 0, 1, 0, 0, 0); clear_counts();
        frame(2, 3, 4, 0, 0, 0, 0, "R2");
        chk(idle_in > 0, "R4", "line-blank pulses, enabled", idle_in, 1);
        chk(idle_out == 0, "R3", "frame-blank pulses, gated", idle_out, 0);

        // S3 fixed-frame, frame-blank clock on
        setcfg(2'b10, 1, 0, 0, 0, 0); clear_counts();
        frame(3, 2, 2, 0, 0, 0, 0, "R2");
        chk(idle_out > 0, "R3", "frame-blank pulses, enabled", idle_out, 1);
        chk(idle_in == 0, "R4", "line-blank pulses, fixed gated", idle_in, 0);

        // S4 continuous, no markers, invalid gated
        setcfg(2'b01, 0, 1, 0, 0, 0); clear_counts();
        frame(2, 4, 3, 1, 0, 0, 0, "R11");
        chk(idle_in == 0, "R5", "invalid pulses, gated", idle_in, 0);
        chk(stalls == 0, "R11", "stall cycles without markers", stalls, 0);

        // S5 continuous with markers, invalid clock on
        setcfg(2'b01, 0, 0, 1, 1, 0); clear_counts();
        frame(2, 3, 3, 1, 1, 0, 0, "R5");
        chk(idle_in > 0, "R5", "invalid pulses, enabled", idle_in, 1);
        chk(stalls == 4, "R6", "stall cycles for marker pairs", stalls, 4);

        // S6 bypass embedded codes, two frames for field bit
        setcfg(2'b00, 0, 0, 0, 0, 1); clear_counts();
        frame(2, 3, 2, 0, 0, 1, 0, "R7");
        chk(stalls == 16, "R7", "stall cycles for codes", stalls, 16);
        frame(1, 2, 2, 0, 0, 1, 0, "R8");
        chk(wire_err == 0, "R7", "valid wires during codes", wire_err, 0);
        repeat (4) @(negedge clk);

        // S7 mid-frame change ignored
        setcfg(2'b00, 0, 0, 0, 0, 0); clear_counts();
        frame(3, 2, 3, 0, 0, 0, 1, "R9");
        chk(idle_in == 0, "R9", "line-blank pulses after mid-frame change", idle_in, 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "bytes left undelivered", exp_q.size(), 0);
        chk(low_err == 0, "R10", "pclk high while clk low", low_err, 0);
        done = 1'b1;
        report();
    end
endmodule